// File: doc/BRIEF.md
# USB Event Interrupt Aggregator

This block gathers the event indications that a USB device core raises and folds them into one active-low interrupt line for an attached processor. Three bus-level conditions (suspend, resume and bus reset) arrive as levels from the bus detector. Six endpoint access strobes and an endpoint-0 NAK strobe arrive as single-cycle pulses. Each endpoint access latches a sticky flag that software can read and clear.

An endpoint flag only reaches the interrupt line when its interrupt enable is set and its pipe is enabled. Endpoint 0 has no pipe enable and is gated by its interrupt enable alone. The three bus conditions always interrupt. Endpoint-0 NAK strobes can be masked. Every new qualifying event drives the line low for a fixed number of clocks. An event that arrives while the line is already low restarts that count.

Software reaches flags, enables and the mask through a small byte-wide register port. Writes take effect at the clock edge and reads are combinational.

Top module: `uev_irq_hub`

## Requirements
- R1: After synchronous reset, `irq_n` is 1 and every register address reads 0x00.
- R2: Address 0 is read-only bus status: bit 0 suspend, bit 1 resume, bit 2 bus reset. Each bit follows its input one clock after the input is sampled. Writes to address 0 have no effect.
- R3: A 0-to-1 change on any bus status bit produces an interrupt pulse whatever the enable and mask settings. A 1-to-0 change produces none.
- R4: An `ep_hit[n]` strobe sets endpoint flag n, read at address 1 in bit n (bits 5..0).
- R5: An endpoint flag clears only when software writes 0 to its bit at address 1. Writing 1 leaves the flag unchanged.
- R6: When an endpoint strobe and a software clear hit the same flag in the same cycle, the flag ends up set.
- R7: Endpoint n (1..5) interrupts only when its flag, its interrupt enable (address 2 bit n) and its pipe enable (address 3 bit n) are all 1. Endpoint 0 needs only its flag and its interrupt enable (address 2 bit 0).
- R8: With the NAK mask (address 4 bit 0) at 0, an `ep0_nak` strobe sets endpoint flag 0. With the mask at 1 the strobe is ignored.
- R9: For an event sampled at clock edge E, `irq_n` is 0 from edge E+1 until edge E+1+PULSE_LEN and 1 otherwise.
- R10: A new event during a pulse restarts it, so the line stays low for PULSE_LEN clocks after the latest event.
- R11: A pulse is triggered only when an endpoint's gated condition goes from 0 to 1. This includes raising an enable while its flag is already set. A further strobe on an endpoint that is already qualified produces no pulse.
- R12: Address 3 bit 0 always reads 0. Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_suspend | input | 1 | Bus suspend level |
| bus_resume | input | 1 | Bus resume level |
| bus_reset | input | 1 | Bus reset level |
| ep_hit | input | 6 | Per-endpoint access strobe |
| ep0_nak | input | 1 | Endpoint-0 NAK strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The gating function is exercised four ways:
- A flag with no enables must stay silent.
- A flag with the interrupt enable but no pipe enable must also stay silent, which isolates the pipe term.
- Raising the pipe enable afterwards must produce a pulse, which shows the trigger follows the gated condition and not the raw strobe.
- An endpoint-0 strobe with no pipe enable must pulse, which separates endpoint 0 from endpoints 1 to 5.

NAK strobes are applied with the mask clear and with it set. Bus levels are raised and dropped with every enable off, to show they bypass the gating and that only rising edges count. A second event two clocks into a pulse distinguishes a restarted count from one that simply runs out. A strobe combined with a clear write in the same cycle shows which of the two wins.

// File: rtl/uev_pkg.sv
package uev_pkg;

    localparam int NUM_EP = 6;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_BUS  = 3'd0,
        RA_FLAG = 3'd1,
        RA_IEN  = 3'd2,
        RA_PIPE = 3'd3,
        RA_CTRL = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic busrst;
        logic resume;
        logic suspend;
    } bus_evt_t;

    typedef struct packed {
        logic [NUM_EP-1:0] ien;
        logic [NUM_EP-1:0] pen;
        logic              nak_mask;
    } cfg_t;

    function automatic logic [NUM_EP-1:0] gate_ep(
        input logic [NUM_EP-1:0] flags,
        input logic [NUM_EP-1:0] ien,
        input logic [NUM_EP-1:0] pen
    );
        return flags & ien & pen;
    endfunction

endpackage

// File: rtl/uev_bus_track.sv
module uev_bus_track
    import uev_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t bus_in,
    output bus_evt_t bus_sts,
    output bus_evt_t bus_rise
);
    bus_evt_t sts_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '0;
            prev_q <= '0;
        end else begin
            sts_q  <= bus_in;
            prev_q <= sts_q;
        end
    end

    assign bus_sts  = sts_q;
    assign bus_rise = sts_q & ~prev_q;

    AST_STS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sts_q == $past(bus_in))) else $error("status lag"); // R2

endmodule

// File: rtl/uev_flag_bank.sv
module uev_flag_bank
    import uev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] ep_hit,
    input  logic              ep0_nak,
    input  cfg_t              cfg,
    input  logic              clr_en,
    input  logic [NUM_EP-1:0] clr_keep,
    output logic [NUM_EP-1:0] flags,
    output logic [NUM_EP-1:0] ep_rise
);
    logic [NUM_EP-1:0] flags_q, gated_prev_q, set_v, gated;

    always_comb begin
        set_v    = ep_hit;
        set_v[0] = ep_hit[0] | (ep0_nak & ~cfg.nak_mask);
    end

    genvar i;
    generate
        for (i = 0; i < NUM_EP; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    flags_q[i] <= 1'b0;
                else if (set_v[i])
                    flags_q[i] <= 1'b1;
                else if (clr_en && !clr_keep[i])
                    flags_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign gated = gate_ep(flags_q, cfg.ien, cfg.pen);

    always_ff @(posedge clk) begin
        if (rst) gated_prev_q <= '0;
        else     gated_prev_q <= gated;
    end

    assign flags   = flags_q;
    assign ep_rise = gated & ~gated_prev_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((flags_q & $past(set_v)) == $past(set_v))) else $error("set lost"); // R6
    AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q))) else $error("flag dropped"); // R5
    AST_MASKED_NAK: assert property (@(posedge clk) disable iff (rst)
        (cfg.nak_mask && ep0_nak && !ep_hit[0] && !flags_q[0]) |=> !flags_q[0]) else $error("nak leak"); // R8

endmodule

// File: rtl/uev_regs.sv
module uev_regs
    import uev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [NUM_EP-1:0] flags,
    input  bus_evt_t          bus_sts,
    output cfg_t              cfg,
    output logic              clr_en,
    output logic [REG_W-1:0]  reg_rdata
);
    logic [NUM_EP-1:0] ien_q;
    logic [NUM_EP-1:1] pen_q;
    logic              mask_q;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[REG_W-1:NUM_EP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            pen_q  <= '0;
            mask_q <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_IEN:  ien_q  <= reg_wdata[NUM_EP-1:0];
                RA_PIPE: pen_q  <= reg_wdata[NUM_EP-1:1];
                RA_CTRL: mask_q <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    assign clr_en       = reg_wr && (reg_addr == RA_FLAG);
    assign cfg.ien      = ien_q;
    assign cfg.pen      = {pen_q, 1'b1};
    assign cfg.nak_mask = mask_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BUS:  reg_rdata[2:0]        = bus_sts;
            RA_FLAG: reg_rdata[NUM_EP-1:0] = flags;
            RA_IEN:  reg_rdata[NUM_EP-1:0] = ien_q;
            RA_PIPE: reg_rdata[NUM_EP-1:1] = pen_q;
            RA_CTRL: reg_rdata[0]          = mask_q;
            default: ;
        endcase
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ($stable(ien_q) && $stable(pen_q) && $stable(mask_q))) else $error("cfg drift"); // R7

endmodule

// File: rtl/uev_pulse_gen.sv
module uev_pulse_gen #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic irq_n
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (trig)         cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign irq_n = (cnt_q == '0);

    AST_TRIG_LOW: assert property (@(posedge clk) disable iff (rst)
        trig |=> !irq_n) else $error("no pulse"); // R9
    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(trig)) else $error("spurious pulse"); // R9

endmodule

// File: rtl/uev_irq_hub.sv
module uev_irq_hub
    import uev_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_suspend,
    input  logic              bus_resume,
    input  logic              bus_reset,
    input  logic [NUM_EP-1:0] ep_hit,
    input  logic              ep0_nak,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_n
);
    bus_evt_t          bus_in, bus_sts, bus_rise;
    cfg_t              cfg;
    logic              clr_en;
    logic [NUM_EP-1:0] flags, ep_rise;
    logic              trig;

    assign bus_in = '{busrst: bus_reset, resume: bus_resume, suspend: bus_suspend};

    uev_bus_track i_bus (
        .clk     (clk),
        .rst     (rst),
        .bus_in  (bus_in),
        .bus_sts (bus_sts),
        .bus_rise(bus_rise)
    );

    uev_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .flags    (flags),
        .bus_sts  (bus_sts),
        .cfg      (cfg),
        .clr_en   (clr_en),
        .reg_rdata(reg_rdata)
    );

    uev_flag_bank i_flags (
        .clk     (clk),
        .rst     (rst),
        .ep_hit  (ep_hit),
        .ep0_nak (ep0_nak),
        .cfg     (cfg),
        .clr_en  (clr_en),
        .clr_keep(reg_wdata[NUM_EP-1:0]),
        .flags   (flags),
        .ep_rise (ep_rise)
    );

    assign trig = (ep_rise != '0) || (bus_rise != '0);

    uev_pulse_gen #(.PULSE_LEN(PULSE_LEN)) i_pulse (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .irq_n(irq_n)
    );

    AST_BUS_UNGATED: assert property (@(posedge clk) disable iff (rst)
        (bus_rise != '0) |=> !irq_n) else $error("bus event gated"); // R3
    AST_EP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (ep_rise != '0) |-> ((ep_rise & ~(cfg.ien & cfg.pen)) == '0)) else $error("ungated ep"); // R7

endmodule

// File: tb/test_uev_irq_hub.sv
`timescale 1ns/1ps
module test_uev_irq_hub;
    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_suspend, bus_resume, bus_reset;
    logic [5:0] ep_hit;
    logic       ep0_nak;
    logic       reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq_n;

    always #4 clk = ~clk;

    uev_irq_hub #(.PULSE_LEN(PL)) i_uev_irq_hub (
        .clk(clk), .rst(rst),
        .bus_suspend(bus_suspend), .bus_resume(bus_resume), .bus_reset(bus_reset),
        .ep_hit(ep_hit), .ep0_nak(ep0_nak),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb[$];
    int  checks = 0;
    int  errors = 0;
    bit  mon_req = 1'b0;
    bit  finished = 1'b0;

    always @(negedge clk) begin
        if (mon_req && sb.size() > 0) begin
            sb_item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = it.is_irq ? {7'b0, irq_n} : reg_rdata;
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: %s got %h expected %h", it.tag,
                         it.is_irq ? "irq_n" : "rdata", got, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        sb.push_back('{is_irq: 1'b0, exp: e, tag: tag});
        mon_req = 1'b1;
        tick();
        mon_req = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            sb.push_back('{is_irq: 1'b1, exp: {7'b0, e}, tag: tag});
            mon_req = 1'b1;
            tick();
            mon_req = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input string tag);
        chk_irq(1'b1, tag, 1);
        chk_irq(1'b0, tag, PL);
        chk_irq(1'b1, tag, 1);
    endtask

    task automatic hit(input logic [5:0] m);
        ep_hit = m; tick(); ep_hit = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run hung");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_suspend = 0; bus_resume = 0; bus_reset = 0;
        ep_hit = '0; ep0_nak = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) chk_rd(3'(a), 8'h00, "R1");
        chk_irq(1'b1, "R1", 1);

        // R4 / R7: flag sets with no enables, no pulse
        hit(6'b000100);
        chk_irq(1'b1, "R7", 3);
        chk_rd(3'd1, 8'h04, "R4");

        // R7: interrupt enable without pipe enable stays silent
        wr(3'd2, 8'h3F);
        chk_irq(1'b1, "R7", 6);
        chk_rd(3'd2, 8'h3F, "R7");

        // R11 / R9: enabling the pipe of a set flag triggers a pulse
        wr(3'd3, 8'h04);
        pulse("R9/R11");
        chk_rd(3'd3, 8'h04, "R7");

        // R11: strobe on already qualified endpoint, no pulse
        hit(6'b000100);
        chk_irq(1'b1, "R11", 6);

        // R5: writing 1 keeps, writing 0 clears
        wr(3'd1, 8'h3F);
        chk_rd(3'd1, 8'h04, "R5");
        wr(3'd1, 8'h00);
        chk_rd(3'd1, 8'h00, "R5");

        // R7: endpoint 0 needs only its interrupt enable
        hit(6'b000001);
        pulse("R7");
        chk_rd(3'd1, 8'h01, "R4");
        wr(3'd1, 8'h00);

        // R8: NAK with mask clear sets flag 0 and pulses
        ep0_nak = 1; tick(); ep0_nak = 0;
        pulse("R8");
        chk_rd(3'd1, 8'h01, "R8");
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h01);
        chk_rd(3'd4, 8'h01, "R8");
        ep0_nak = 1; tick(); ep0_nak = 0;
        chk_irq(1'b1, "R8", 6);
        chk_rd(3'd1, 8'h00, "R8");

        // R6: set and clear in the same cycle
        hit(6'b100000);
        reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'h00; ep_hit = 6'b001000;
        tick();
        reg_wr = 0; ep_hit = '0;
        chk_rd(3'd1, 8'h08, "R6");
        wr(3'd1, 8'h00);

        // R10: retrigger during a pulse
        wr(3'd3, 8'h3E);
        hit(6'b000010);
        chk_irq(1'b1, "R10", 1);
        chk_irq(1'b0, "R10", 1);
        ep_hit = 6'b000100;
        chk_irq(1'b0, "R10", 1);
        ep_hit = '0;
        chk_irq(1'b0, "R10", 5);
        chk_irq(1'b1, "R10", 1);
        wr(3'd1, 8'h00);

        // R2 / R3: bus conditions bypass every enable
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        bus_suspend = 1; tick();
        pulse("R3");
        chk_rd(3'd0, 8'h01, "R2");
        wr(3'd0, 8'hFF);
        chk_rd(3'd0, 8'h01, "R2");
        bus_resume = 1; tick();
        pulse("R3");
        chk_rd(3'd0, 8'h03, "R2");
        bus_suspend = 0; bus_resume = 0; tick();
        chk_irq(1'b1, "R3", 6);
        chk_rd(3'd0, 8'h00, "R2");
        bus_reset = 1; tick();
        pulse("R3");
        chk_rd(3'd0, 8'h04, "R2");
        bus_reset = 0; tick();

        // R12: pipe bit 0 and unmapped addresses
        wr(3'd3, 8'hFF);
        chk_rd(3'd3, 8'h3E, "R12");
        chk_rd(3'd5, 8'h00, "R12");
        chk_rd(3'd7, 8'h00, "R12");
        wr(3'd4, 8'hFE);
        chk_rd(3'd4, 8'h00, "R12");

        repeat (2) tick();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule